// File: doc/BRIEF.md
# Event-Counting Interrupt Prescaler

This block sits behind a timer's event selector and thins the stream of qualifying events into interrupts. It counts event strobes in a small counter and, once the count reaches a programmed period of one to three events, sends a single-cycle interrupt pulse and returns the counter to zero. A sticky status flag is set with every pulse. While that flag is set, or while the interrupt enable is off, no further pulse goes out. Instead the counter climbs to the period and waits there, so exactly one interrupt stays pending until software clears the flag.

Software programs the period and the enable through a one-word write port. It clears the status flag with a strobe and can raise an interrupt directly with a force strobe. The counter value can be read back on a zero-extended output word. A period of zero switches the counter off entirely.

Top module: `evtPrescale`

## Requirements
- R1: After an active-low synchronous reset, the interrupt pulse, status flag, counter, period and enable are all zero, and every bit of `cntRead` above the 2-bit counter reads as zero at all times.
- R2: With period N (1 to 3), the enable set and the flag clear, the counter increments on each event. In the cycle after the counter equals N, `intPulse` is high for exactly one cycle and the counter returns to zero.
- R3: `intFlag` rises together with `intPulse`. While the flag is set or the enable is 0, no pulse is produced, and the counter increments only up to the period and then holds.
- R4: After a clear strobe removes the flag, a count held at the period produces a pulse in the next cycle. When a clear strobe and a pulse fall in the same cycle, the flag ends up set.
- R5: A period of 0 stops counting of events (outside the write cycle), produces no interrupt, and makes the force strobe have no effect.
- R6: Writing a period equal to the current count produces a pulse in the cycle after the write takes effect, provided the enable is set and the flag is clear.
- R7: An event arriving in the same cycle as a write to the configuration word increments the counter (saturating at 3), unless the counter is being cleared by an interrupt in that cycle. This holds whether the new period is zero or not.
- R8: If the period is written below the current count, the count counts as having reached the period. It fires if allowed, and otherwise the counter is lowered to the new period one cycle after the write.
- R9: With a non-zero period, the force strobe produces a pulse and sets the flag one cycle later, under the same enable and flag conditions as a counted interrupt, and leaves the counter unchanged.
- R10: In a configuration write, `cfgWrData[1:0]` is the period and `cfgWrData[2]` is the enable. Other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 1 | Qualifying event, one per high cycle |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 16 | Configuration word: [1:0] period, [2] enable |
| flagClr | input | 1 | Clears the status flag |
| forceStrobe | input | 1 | Software interrupt request |
| intPulse | output | 1 | Single-cycle interrupt pulse |
| intFlag | output | 1 | Sticky interrupt status flag |
| cntRead | output | 16 | Event counter, zero-extended |

## Verification
The hardest situations to reach are the ones where the count is already parked and the period or the flag changes beneath it. Examples are a period rewritten to equal the parked count, a period rewritten below it, and a flag clear landing in the same cycle as the pulse it releases. The stimulus first disables the enable or leaves the flag set so that the counter saturates at a known value. It then issues the period write or the clear on chosen cycles, and it checks both the cycle in which the pulse appears and the value the counter takes afterwards.

// File: rtl/evtPrescalePkg.sv
package evtPrescalePkg;
  typedef struct packed {
    logic fire;
    logic clrCnt;
  } ctlStrobe_t;
endpackage

// File: rtl/evtPrescaleDatapath.sv
module evtPrescaleDatapath
  import evtPrescalePkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStrobe,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  ctlStrobe_t        ctl,
  output logic [CNT_W-1:0]  prdQ,
  output logic              enQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [DATA_W-1:0] cntRead
);
  localparam int EN_BIT = CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic prdOn;
  logic incOk;
  assign prdOn = (prdQ != '0);
  assign incOk = evtStrobe && (cfgWrEn || (prdOn && (cntQ < prdQ)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdQ <= '0;
      enQ  <= 1'b0;
      cntQ <= '0;
    end else begin
      if (cfgWrEn) begin
        prdQ <= cfgWrData[CNT_W-1:0];
        enQ  <= cfgWrData[EN_BIT];
      end
      if (ctl.clrCnt) begin
        cntQ <= '0;
      end else if (incOk) begin
        if (cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
      end else if (!cfgWrEn && prdOn && (cntQ > prdQ)) begin
        cntQ <= prdQ;
      end
    end
  end

  assign cntRead = {{(DATA_W-CNT_W){1'b0}}, cntQ};

  // R3: with a steady non-zero period the count never climbs past it
  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && prdOn && (cntQ <= prdQ)) |=> (cntQ <= $past(prdQ)));

  // R5: a zero period freezes the counter outside write cycles
  assert_off_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !prdOn) |=> $stable(cntQ));

  // R7: an event coinciding with a write still counts
  assert_wr_evt_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && evtStrobe && !ctl.clrCnt && (cntQ != CNT_MAX))
      |=> (cntQ == $past(cntQ) + 1'b1));
endmodule

// File: rtl/evtPrescaleControl.sv
module evtPrescaleControl
  import evtPrescalePkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] prdQ,
  input  logic             enQ,
  input  logic [CNT_W-1:0] cntQ,
  input  logic             flagClr,
  input  logic             forceStrobe,
  output ctlStrobe_t       ctl,
  output logic             intPulse,
  output logic             intFlag
);
  logic prdOn, reach, allow, fireNow;
  logic pulseQ, flagQ;

  assign prdOn   = (prdQ != '0);
  assign reach   = prdOn && (cntQ >= prdQ);
  assign allow   = enQ && !flagQ && prdOn;
  assign fireNow = allow && (reach || forceStrobe);

  always_comb begin
    ctl.fire   = fireNow;
    ctl.clrCnt = allow && reach;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      pulseQ <= fireNow;
      if (fireNow)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  assign intPulse = pulseQ;
  assign intFlag  = flagQ;

  // R2: the interrupt is a single-cycle pulse
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);

  // R3: the flag only rises together with a pulse
  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> pulseQ);

  // R5: no interrupt while the period is zero
  assert_no_fire_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !prdOn |=> !pulseQ);

  // R4: set wins over a coinciding clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fireNow && flagClr) |=> flagQ);
endmodule

// File: rtl/evtPrescale.sv
module evtPrescale
  import evtPrescalePkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStrobe,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              flagClr,
  input  logic              forceStrobe,
  output logic              intPulse,
  output logic              intFlag,
  output logic [DATA_W-1:0] cntRead
);
  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] prdQ;
  logic [CNT_W-1:0] cntQ;
  logic             enQ;

  evtPrescaleDatapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .ctl(ctl), .prdQ(prdQ), .enQ(enQ),
    .cntQ(cntQ), .cntRead(cntRead)
  );

  evtPrescaleControl #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .prdQ(prdQ), .enQ(enQ), .cntQ(cntQ),
    .flagClr(flagClr), .forceStrobe(forceStrobe), .ctl(ctl),
    .intPulse(intPulse), .intFlag(intFlag)
  );
endmodule

// File: tb/evtPrescale_test.sv
module evtPrescale_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtStrobe = 1'b0, cfgWrEn = 1'b0, flagClr = 1'b0, forceStrobe = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic intPulse, intFlag;
  logic [15:0] cntRead;

  always #2 clk = ~clk;

  evtPrescale uut (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .flagClr(flagClr), .forceStrobe(forceStrobe),
    .intPulse(intPulse), .intFlag(intFlag), .cntRead(cntRead)
  );

  typedef struct {
    logic        pulse;
    logic        flag;
    logic [15:0] cnt;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic step(input logic evt, input logic wr, input logic [15:0] wd,
                      input logic clr, input logic frc, input logic ePulse,
                      input logic eFlag, input logic [15:0] eCnt, input string tag);
    expItem_t it;
    @(negedge clk);
    evtStrobe = evt; cfgWrEn = wr; cfgWrData = wd; flagClr = clr; forceStrobe = frc;
    it.pulse = ePulse; it.flag = eFlag; it.cnt = eCnt; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (intPulse !== it.pulse || intFlag !== it.flag || cntRead !== it.cnt) begin
          errors++;
          $display("FAIL %s: pulse/flag/cnt got %0b/%0b/%0d expected %0b/%0b/%0d",
                   it.tag, intPulse, intFlag, cntRead, it.pulse, it.flag, it.cnt);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    // R1 reset state
    step(1, 1, 16'h0007, 0, 1, 0, 0, 0, "R1 in reset");
    step(0, 0, 16'h0000, 0, 0, 0, 0, 0, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    // R10 period in [1:0], enable in [2]; R2 fire on third event
    step(0, 1, 16'hFFF7, 0, 0, 0, 0, 0, "R10 write en=1 prd=3");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R2 count 1");
    step(1, 0, 0, 0, 0, 0, 0, 2, "R2 count 2");
    step(1, 0, 0, 0, 0, 0, 0, 3, "R2 count 3");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R2 pulse and clear");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R2 pulse single cycle");
    // R3 blocked by flag, saturate at period
    step(1, 0, 0, 0, 0, 0, 1, 1, "R3 blocked count 1");
    step(1, 0, 0, 0, 0, 0, 1, 2, "R3 blocked count 2");
    step(1, 0, 0, 0, 0, 0, 1, 3, "R3 blocked count 3");
    step(1, 0, 0, 0, 0, 0, 1, 3, "R3 saturate at period");
    // R4 clear releases pending, set wins over coinciding clear
    step(0, 0, 0, 1, 0, 0, 0, 3, "R4 flag cleared");
    step(0, 0, 0, 1, 0, 1, 1, 0, "R4 pending fires, set wins");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R4 clear");
    // R5 period zero
    step(0, 1, 16'h0004, 0, 0, 0, 0, 0, "R5 write prd=0");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5 no counting");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R5 force ignored");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5 no pulse");
    // R7 event with write increments
    step(1, 1, 16'h0006, 0, 0, 0, 0, 1, "R7 write+event");
    step(1, 0, 0, 0, 0, 0, 0, 2, "R2 count 2 of 2");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R2 pulse prd=2");
    // R6 equal write
    step(0, 0, 0, 1, 0, 0, 0, 0, "R4 clear");
    step(0, 1, 16'h0003, 0, 0, 0, 0, 0, "R3 write en=0 prd=3");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R3 disabled count 1");
    step(1, 0, 0, 0, 0, 0, 0, 2, "R3 disabled count 2");
    step(0, 1, 16'h0006, 0, 0, 0, 0, 2, "R6 write prd=count");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R6 fires at once");
    // R8 smaller period
    step(0, 0, 0, 1, 0, 0, 0, 0, "R4 clear");
    step(0, 1, 16'h0003, 0, 0, 0, 0, 0, "R8 write en=0 prd=3");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R8 count 1");
    step(1, 0, 0, 0, 0, 0, 0, 2, "R8 count 2");
    step(1, 0, 0, 0, 0, 0, 0, 3, "R8 count 3");
    step(0, 1, 16'h0001, 0, 0, 0, 0, 3, "R8 write smaller prd");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8 lowered to period");
    step(0, 1, 16'h0005, 0, 0, 0, 0, 1, "R8 enable");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R8 fires when allowed");
    // R9 force
    step(0, 0, 0, 0, 1, 0, 1, 0, "R9 force blocked by flag");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R4 clear");
    step(0, 1, 16'h0007, 0, 0, 0, 0, 0, "R9 write prd=3");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R9 count 1");
    step(0, 0, 0, 0, 1, 1, 1, 1, "R9 force fires, count kept");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R9 single pulse");
    @(negedge clk);
    evtStrobe = 0; cfgWrEn = 0; flagClr = 0; forceStrobe = 0;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule